// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Transmit Buffer

This block holds outgoing packet data for a single bulk or interrupt IN endpoint of a USB device. Firmware writes packet bytes into one of two banks and then commits the bank. On commit, the firmware-side write pointer moves at once to the other bank, so firmware can prepare the next packet while the previous one waits for the host or is on the wire.

On the bus side, a simplified serial engine reports IN tokens, pulls packet bytes one at a time and then reports whether the host acknowledged the packet. For each token the block either refuses with a NAK or starts a data packet. A data packet carries the committed byte count and the current data toggle.

Banks are sent in the order they were committed. A host acknowledge frees the bank, advances the toggle and raises a shared completion flag, which firmware clears by writing one. A packet that ends without acknowledge is sent again unchanged on the next token. Byte writes that would corrupt a committed bank, or that would go past the bank capacity, are dropped and recorded in a sticky error flag.

Top module: `in_ep_pingpong`

## Requirements
- R1: While `cfgEnable` is low, IN tokens get neither `rspNak` nor `rspData`, and firmware writes and commits are ignored. On re-enable the block restarts with the write bank at 0, no bank ready, toggle DATA0 (`pktToggle`=0), `txDone` low and `ovfErr` low.
- R2: An accepted byte write stores `fwWrData` at the next free offset of the current write bank. A pulse on `fwCommit` to a bank that is not ready marks that bank ready and flips `fwBank` (0 or 1) on the following edge.
- R3: An IN token that arrives while idle, for a transmit bank that is not ready, raises `rspNak` for exactly one cycle after the token edge. This repeats for every such token.
- R4: An IN token for a ready bank raises `rspData` for one cycle after the token edge, with `pktLen` equal to the number of bytes accepted into that bank. The bytes are then offered on `txByte` with `txValid` in write order, advancing on each `txReady`, and `txLast` marks the final byte. A zero-length packet raises `rspData` with `pktLen`=0 and offers no byte.
- R5: A host acknowledge (`hsAck`) after a packet frees that bank and sets `txDone` on the next edge. `irq` equals `txDone` AND `intEnable`.
- R6: Banks are transmitted alternately, starting with bank 0, in commit order. The toggle starts at DATA0 and inverts after every acknowledged packet.
- R7: A packet that ends with `hsFail` and no acknowledge leaves its bank ready and its toggle unchanged, so the next token resends the same bytes with the same toggle.
- R8: A byte write to a bank that is committed and not yet acknowledged, or a write beyond `FIFO_DEPTH` bytes, is dropped and sets the sticky `ovfErr`. The bank contents and count are unchanged, and `pktLen` never exceeds `FIFO_DEPTH`.
- R9: A pulse on `fwClearDone` clears `txDone`. If an acknowledge arrives in the same cycle, the acknowledge wins and `txDone` stays set.
- R10: IN tokens that arrive while a packet is being streamed or is awaiting its handshake get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Endpoint enabled and configured |
| intEnable | input | 1 | Endpoint interrupt enable |
| fwWrValid | input | 1 | Firmware byte write strobe |
| fwWrData | input | DATA_W | Firmware byte |
| fwCommit | input | 1 | Commit current write bank (transmit ready) |
| fwClearDone | input | 1 | Write-one-to-clear of the completion flag |
| fwBank | output | 1 | Bank that firmware writes next |
| txDone | output | 1 | Transmit-complete flag |
| irq | output | 1 | Endpoint interrupt request |
| ovfErr | output | 1 | Sticky dropped-write error |
| tokIn | input | 1 | IN token for this endpoint |
| rspNak | output | 1 | Answer NAK to the token |
| rspData | output | 1 | Start a data packet for the token |
| pktLen | output | CNT_W | Byte count of the packet being sent |
| pktToggle | output | 1 | Data toggle, 0 = DATA0, 1 = DATA1 |
| txValid | output | 1 | Packet byte available |
| txByte | output | DATA_W | Packet byte |
| txLast | output | 1 | Current byte is the last one |
| txReady | input | 1 | Serial engine takes the byte |
| hsAck | input | 1 | Host acknowledged the packet |
| hsFail | input | 1 | Packet ended without acknowledge |

## Verification
Directed sequences cover several cases: tokens with no bank ready, which tell NAK apart from silence while disabled; a fail followed by a resend, which shows that the toggle and the bank are kept; and a zero-length packet. Writes into a committed bank and an over-long write show that dropped bytes never reach the wire. A random phase then mixes commits of random lengths, tokens on an empty queue and randomly failed handshakes. Each packet carries a byte pattern computed from its identity, so any misordered bank, stale byte or wrong toggle shows up against the expected packet.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } txState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic rdClr;   // restart read offset for a new packet
    logic rdAdv;   // serial engine consumed one byte
    logic retire;  // transmit bank acknowledged, free it
  } dpStrobe_t;

endpackage

// File: rtl/in_ep_datapath.sv
module in_ep_datapath
  import in_ep_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int IDX_W      = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgEnable,
  input  logic              fwWrValid,
  input  logic [DATA_W-1:0] fwWrData,
  input  logic              fwCommit,
  input  dpStrobe_t         strobe,
  input  logic              txBank,
  output logic [DATA_W-1:0] txByte,
  output logic [CNT_W-1:0]  pktLen,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [1:0]        readyMask,
  output logic              wrBank,
  output logic              ovfErr
);

  logic [CNT_W-1:0]  wrCnt;
  logic [CNT_W-1:0]  cntNext;
  logic              wrCurReady;
  logic              wrAccept;
  logic              wrReject;
  logic              commitOk;
  logic [CNT_W-1:0]  lenArr  [2];
  logic [DATA_W-1:0] byteArr [2];

  assign wrCurReady = readyMask[wrBank];
  assign wrAccept   = cfgEnable && fwWrValid && !wrCurReady &&
                      (wrCnt < CNT_W'(FIFO_DEPTH));
  assign wrReject   = cfgEnable && fwWrValid && !wrAccept;
  assign commitOk   = cfgEnable && fwCommit && !wrCurReady;
  assign cntNext    = wrCnt + CNT_W'(wrAccept);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] store [FIFO_DEPTH];
    logic [CNT_W-1:0]  lenQ;
    logic              readyQ;
    logic              selWr;
    logic              selTx;

    assign selWr = (wrBank == 1'(b));
    assign selTx = (txBank == 1'(b));

    always_ff @(posedge clk) begin
      if (wrAccept && selWr) begin
        store[wrCnt[IDX_W-1:0]] <= fwWrData;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        readyQ <= 1'b0;
        lenQ   <= '0;
      end else if (!cfgEnable) begin
        readyQ <= 1'b0;
        lenQ   <= '0;
      end else if (commitOk && selWr) begin
        readyQ <= 1'b1;
        lenQ   <= cntNext;
      end else if (strobe.retire && selTx) begin
        readyQ <= 1'b0;
      end
    end

    assign readyMask[b] = readyQ;
    assign lenArr[b]    = lenQ;
    assign byteArr[b]   = store[rdIdx];
  end

  // firmware-side pointer and sticky error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrBank <= 1'b0;
      wrCnt  <= '0;
      ovfErr <= 1'b0;
    end else if (!cfgEnable) begin
      wrBank <= 1'b0;
      wrCnt  <= '0;
      ovfErr <= 1'b0;
    end else begin
      if (wrReject) begin
        ovfErr <= 1'b1;
      end
      if (commitOk) begin
        wrBank <= ~wrBank;
        wrCnt  <= '0;
      end else begin
        wrCnt  <= cntNext;
      end
    end
  end

  // read offset into the transmit bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdIdx <= '0;
    end else if (!cfgEnable || strobe.rdClr) begin
      rdIdx <= '0;
    end else if (strobe.rdAdv) begin
      rdIdx <= rdIdx + 1'b1;
    end
  end

  assign txByte = byteArr[txBank];
  assign pktLen = lenArr[txBank];

endmodule

// File: rtl/in_ep_ctrl.sv
module in_ep_ctrl
  import in_ep_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int IDX_W      = $clog2(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgEnable,
  input  logic             intEnable,
  input  logic             tokIn,
  input  logic             txReady,
  input  logic             hsAck,
  input  logic             hsFail,
  input  logic             fwClearDone,
  input  logic [1:0]       readyMask,
  input  logic [CNT_W-1:0] pktLen,
  input  logic [IDX_W-1:0] rdIdx,
  output dpStrobe_t        strobe,
  output logic             txBank,
  output logic             pktToggle,
  output logic             rspNak,
  output logic             rspData,
  output logic             txValid,
  output logic             txLast,
  output logic             txDone,
  output logic             irq,
  output logic             awaitHs,
  output logic             ctrlIdle
);

  txState_e  stateQ, stateN;
  logic      bankN, togN;
  logic      nakN, dataN, doneSet;
  logic      lastByte;
  dpStrobe_t stb;

  assign lastByte = ((CNT_W'(rdIdx) + CNT_W'(1)) == pktLen);

  always_comb begin
    stateN  = stateQ;
    stb     = '0;
    nakN    = 1'b0;
    dataN   = 1'b0;
    bankN   = txBank;
    togN    = pktToggle;
    doneSet = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (tokIn) begin
          if (readyMask[txBank]) begin
            dataN     = 1'b1;
            stb.rdClr = 1'b1;
            stateN    = (pktLen == '0) ? ST_WAIT : ST_SEND;
          end else begin
            nakN = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (txReady) begin
          stb.rdAdv = 1'b1;
          if (lastByte) begin
            stateN = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (hsAck) begin
          stb.retire = 1'b1;
          bankN      = ~txBank;
          togN       = ~pktToggle;
          doneSet    = 1'b1;
          stateN     = ST_IDLE;
        end else if (hsFail) begin
          stateN = ST_IDLE;
        end
      end
      default: stateN = ST_IDLE;
    endcase
    if (!cfgEnable) begin
      stb = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ    <= ST_IDLE;
      txBank    <= 1'b0;
      pktToggle <= 1'b0;
      txDone    <= 1'b0;
      rspNak    <= 1'b0;
      rspData   <= 1'b0;
    end else if (!cfgEnable) begin
      stateQ    <= ST_IDLE;
      txBank    <= 1'b0;
      pktToggle <= 1'b0;
      txDone    <= 1'b0;
      rspNak    <= 1'b0;
      rspData   <= 1'b0;
    end else begin
      stateQ    <= stateN;
      txBank    <= bankN;
      pktToggle <= togN;
      rspNak    <= nakN;
      rspData   <= dataN;
      txDone    <= doneSet | (txDone & ~fwClearDone);
    end
  end

  assign strobe   = stb;
  assign txValid  = (stateQ == ST_SEND);
  assign txLast   = (stateQ == ST_SEND) && lastByte;
  assign irq      = txDone && intEnable;
  assign awaitHs  = (stateQ == ST_WAIT);
  assign ctrlIdle = (stateQ == ST_IDLE);

endmodule

// File: rtl/in_ep_pingpong.sv
module in_ep_pingpong
  import in_ep_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int IDX_W     = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgEnable,
  input  logic              intEnable,
  input  logic              fwWrValid,
  input  logic [DATA_W-1:0] fwWrData,
  input  logic              fwCommit,
  input  logic              fwClearDone,
  output logic              fwBank,
  output logic              txDone,
  output logic              irq,
  output logic              ovfErr,
  input  logic              tokIn,
  output logic              rspNak,
  output logic              rspData,
  output logic [CNT_W-1:0]  pktLen,
  output logic              pktToggle,
  output logic              txValid,
  output logic [DATA_W-1:0] txByte,
  output logic              txLast,
  input  logic              txReady,
  input  logic              hsAck,
  input  logic              hsFail
);

  dpStrobe_t        strobe;
  logic             txBank;
  logic [1:0]       readyMask;
  logic [IDX_W-1:0] rdIdx;
  logic             awaitHs;
  logic             ctrlIdle;
  logic             curReady;

  assign curReady = readyMask[txBank];

  in_ep_ctrl #(
    .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgEnable(cfgEnable), .intEnable(intEnable),
    .tokIn(tokIn), .txReady(txReady), .hsAck(hsAck), .hsFail(hsFail),
    .fwClearDone(fwClearDone), .readyMask(readyMask), .pktLen(pktLen),
    .rdIdx(rdIdx), .strobe(strobe), .txBank(txBank), .pktToggle(pktToggle),
    .rspNak(rspNak), .rspData(rspData), .txValid(txValid), .txLast(txLast),
    .txDone(txDone), .irq(irq), .awaitHs(awaitHs), .ctrlIdle(ctrlIdle)
  );

  in_ep_datapath #(
    .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cfgEnable(cfgEnable), .fwWrValid(fwWrValid),
    .fwWrData(fwWrData), .fwCommit(fwCommit), .strobe(strobe),
    .txBank(txBank), .txByte(txByte), .pktLen(pktLen), .rdIdx(rdIdx),
    .readyMask(readyMask), .wrBank(fwBank), .ovfErr(ovfErr)
  );

endmodule

// File: rtl/in_ep_checker.sv
module in_ep_checker #(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfgEnable,
  input logic             tokIn,
  input logic             rspNak,
  input logic             rspData,
  input logic             hsAck,
  input logic             hsFail,
  input logic             fwClearDone,
  input logic             txDone,
  input logic             pktToggle,
  input logic [CNT_W-1:0] pktLen,
  input logic             awaitHs,
  input logic             ctrlIdle,
  input logic             curReady
);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgEnable |=> !rspData && !rspNak); // R1

  AST_NAK_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    cfgEnable && ctrlIdle && tokIn && !curReady |=> rspNak && !rspData); // R3

  AST_DATA_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cfgEnable && ctrlIdle && tokIn && curReady |=> rspData && !rspNak); // R4

  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfgEnable && awaitHs && hsAck |=> txDone); // R5

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    cfgEnable && awaitHs && hsAck |=> pktToggle != $past(pktToggle)); // R6

  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    cfgEnable && awaitHs && !hsAck && hsFail |=> $stable(pktToggle) && curReady); // R7

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pktLen) <= FIFO_DEPTH); // R8

  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfgEnable && fwClearDone && !(awaitHs && hsAck) |=> !txDone); // R9

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlIdle |=> !rspNak && !rspData); // R10

endmodule

bind in_ep_pingpong in_ep_checker #(
  .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfgEnable(cfgEnable), .tokIn(tokIn),
  .rspNak(rspNak), .rspData(rspData), .hsAck(hsAck), .hsFail(hsFail),
  .fwClearDone(fwClearDone), .txDone(txDone), .pktToggle(pktToggle),
  .pktLen(pktLen), .awaitHs(awaitHs), .ctrlIdle(ctrlIdle), .curReady(curReady)
);

// File: tb/in_ep_pingpong_bench.sv
module in_ep_pingpong_bench;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n, cfgEnable, intEnable, fwWrValid, fwCommit, fwClearDone;
  logic [7:0] fwWrData;
  logic fwBank, txDone, irq, ovfErr, tokIn, rspNak, rspData, pktToggle;
  logic txValid, txLast, txReady, hsAck, hsFail;
  logic [CW-1:0] pktLen;
  logic [7:0] txByte;

  int nChk = 0, nFail = 0;
  int expTog = 0;
  int expWrBank = 0;

  always #5 clk = ~clk;

  in_ep_pingpong #(.DATA_W(8), .FIFO_DEPTH(DEPTH)) u_in_ep_pingpong (
    .clk(clk), .rst_n(rst_n), .cfgEnable(cfgEnable), .intEnable(intEnable),
    .fwWrValid(fwWrValid), .fwWrData(fwWrData), .fwCommit(fwCommit),
    .fwClearDone(fwClearDone), .fwBank(fwBank), .txDone(txDone), .irq(irq),
    .ovfErr(ovfErr), .tokIn(tokIn), .rspNak(rspNak), .rspData(rspData),
    .pktLen(pktLen), .pktToggle(pktToggle), .txValid(txValid), .txByte(txByte),
    .txLast(txLast), .txReady(txReady), .hsAck(hsAck), .hsFail(hsFail)
  );

  function automatic logic [7:0] patByte(int id, int i);
    return 8'((id * 37 + i * 11 + 5) ^ (i << 3));
  endfunction

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
  endtask

  task automatic writeBytes(int id, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fwWrValid = 1'b1; fwWrData = patByte(id, i);
    end
    @(negedge clk); fwWrValid = 1'b0;
  endtask

  task automatic commit(int expBank);
    @(negedge clk); fwCommit = 1'b1;
    @(negedge clk); fwCommit = 1'b0;
    check("R2 write bank after commit", fwBank, expBank);
  endtask

  task automatic nakToken();
    @(negedge clk); tokIn = 1'b1;
    @(posedge clk); #1;
    check("R3 nak for unready bank", rspNak, 1);
    check("R3 no data for unready bank", rspData, 0);
    @(negedge clk); tokIn = 1'b0;
  endtask

  task automatic clearDone();
    @(negedge clk); fwClearDone = 1'b1;
    @(negedge clk); fwClearDone = 1'b0;
    check("R9 clear of done flag", txDone, 0);
  endtask

  // mode: 0 ack, 1 fail, 2 ack together with a clear
  task automatic sendPacket(int id, int len, int mode, bit poke);
    @(negedge clk); tokIn = 1'b1;
    @(posedge clk); #1;
    check("R4 data response", rspData, 1);
    check("R4 no nak with data", rspNak, 0);
    check("R4 packet length", pktLen, len);
    check("R6 data toggle", pktToggle, expTog);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      tokIn = poke && (i == 0);
      if (i > 0) check("R10 silent while busy", int'(rspNak) + int'(rspData), 0);
      check("R4 byte valid", txValid, 1);
      check("R4 byte value", txByte, patByte(id, i));
      check("R4 last marker", txLast, (i == len - 1) ? 1 : 0);
      txReady = 1'b1;
    end
    @(negedge clk); tokIn = 1'b0; txReady = 1'b0;
    check("R4 stream ended", txValid, 0);
    check("R10 no reply to token during stream", rspNak, 0);
    if (mode == 1) hsFail = 1'b1;
    else hsAck = 1'b1;
    if (mode == 2) fwClearDone = 1'b1;
    @(negedge clk); hsAck = 1'b0; hsFail = 1'b0; fwClearDone = 1'b0;
    if (mode == 1) begin
      check("R7 no completion on fail", txDone, 0);
    end else begin
      check(mode == 2 ? "R9 ack beats clear" : "R5 done after ack", txDone, 1);
      check("R5 irq gating", irq, int'(intEnable));
      expTog ^= 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    int pendId[2];
    int pendLen[2];
    int head, cnt, nextId;
    void'($urandom(32'h1d5e_ed01));
    rst_n = 1'b0; cfgEnable = 1'b0; intEnable = 1'b0; fwWrValid = 1'b0;
    fwWrData = '0; fwCommit = 1'b0; fwClearDone = 1'b0; tokIn = 1'b0;
    txReady = 1'b0; hsAck = 1'b0; hsFail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset done", txDone, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset ovf", ovfErr, 0);
    check("R1 reset bank", fwBank, 0);
    check("R1 reset toggle", pktToggle, 0);

    // disabled: token, writes and commit are ignored
    writeBytes(50, 2);
    @(negedge clk); fwCommit = 1'b1;
    @(negedge clk); fwCommit = 1'b0;
    check("R1 commit ignored while disabled", fwBank, 0);
    @(negedge clk); tokIn = 1'b1;
    @(posedge clk); #1;
    check("R1 silent while disabled", int'(rspNak) + int'(rspData), 0);
    @(negedge clk); tokIn = 1'b0;

    cfgEnable = 1'b1; intEnable = 1'b1;
    @(negedge clk);
    nakToken(); nakToken();

    writeBytes(1, 5); commit(1);
    sendPacket(1, 5, 0, 0); clearDone();
    check("R5 irq low after clear", irq, 0);
    writeBytes(2, 3); commit(0);
    sendPacket(2, 3, 2, 0); clearDone();

    // R7 fail then resend, token poked during stream (R10)
    writeBytes(3, 4); commit(1);
    sendPacket(3, 4, 1, 0);
    sendPacket(3, 4, 0, 1); clearDone();
    // zero-length packet from bank 1
    commit(0);
    sendPacket(0, 0, 0, 0); clearDone();

    // R8 writes into committed banks and past capacity
    intEnable = 1'b0;
    writeBytes(5, 2); commit(1);
    writeBytes(6, 3); commit(0);
    writeBytes(99, 1);
    check("R8 ovf on write to committed bank", ovfErr, 1);
    commit(0);
    sendPacket(5, 2, 0, 0); clearDone();
    sendPacket(6, 3, 0, 0); clearDone();
    nakToken();
    writeBytes(7, DEPTH + 3); commit(1);
    check("R8 ovf sticky", ovfErr, 1);
    sendPacket(7, DEPTH, 0, 0); clearDone();

    // R1 reconfiguration restart
    @(negedge clk); cfgEnable = 1'b0;
    @(negedge clk); cfgEnable = 1'b1;
    @(negedge clk);
    check("R1 ovf cleared by reconfig", ovfErr, 0);
    check("R1 bank 0 after reconfig", fwBank, 0);
    check("R1 toggle DATA0 after reconfig", pktToggle, 0);
    expTog = 0; expWrBank = 0;
    nakToken();

    // random mix
    head = 0; cnt = 0; nextId = 10;
    intEnable = 1'b1;
    for (int it = 0; it < 80; it++) begin
      int r;
      r = int'($urandom % 4);
      if (r < 2 && cnt < 2) begin
        int len;
        len = int'($urandom % (DEPTH + 1));
        writeBytes(nextId, len);
        expWrBank ^= 1;
        commit(expWrBank);
        pendId[(head + cnt) % 2] = nextId;
        pendLen[(head + cnt) % 2] = len;
        cnt++; nextId++;
      end else if (cnt == 0) begin
        nakToken();
      end else begin
        bit fl;
        fl = ($urandom % 4) == 0;
        sendPacket(pendId[head], pendLen[head], fl ? 1 : 0, 1'b0);
        if (!fl) begin
          head = (head + 1) % 2; cnt--;
          clearDone();
        end
      end
    end
    summary();
    $finish;
  end
endmodule